// File: doc/BRIEF.md
# Two-Channel Serial PCM Transmitter with Control Echo

This block turns one outbound frame of a two-channel voice line card into a serial bit stream. Each frame carries one compressed 8-bit sample per channel. It also carries a set of echo bits, so the far end can confirm the latched control outputs and the power state of each channel without a separate read path. A rising edge on the frame sync input starts a frame. At that edge every field is copied into a shadow register, and the first bit leaves on the same clock edge. The remaining bits follow, one per rising clock edge.

The serial line is open-drain. `tx_oe` marks the cycles in which the block owns the line. `tx_bit` is the level the line takes with its pull-up, so a released line reads 1. A channel whose power bit is 0 sends the idle code in its sample slot. A global active-low power-down input releases the line at once and holds it released.

Top module: `pcm_tx_echo`

## Requirements
- R1: After reset, `tx_oe` is 0 and `tx_bit` is 1.
- R2: A frame starts at the first rising clock edge where `fsync` is 1 and was 0 at the previous edge (with `pd_n` high). After that edge, bit 1 (the channel A sample MSB) is on the line with `tx_oe` = 1. Bit n appears after edge n−1 of the frame.
- R3: The frame is 28 bits, sent in this order:
  - bits 1–8: `pcm_a` MSB first
  - bit 9: `pwr_a`
  - bits 10–12: `lat_a[2]`, `lat_a[1]`, `lat_a[0]`
  - bits 13–16: unused
  - bits 17–24: `pcm_b` MSB first
  - bit 25: `pwr_b`
  - bits 26–28: `lat_b[2]`, `lat_b[1]`, `lat_b[0]`
- R4: When a channel's power bit is 0 at the frame start, its eight sample bits are all 1 (the idle code 8'hFF), whatever its sample input holds.
- R5: The echo bits (the power bit and the three latch bits of each channel) carry the values present on those inputs at the frame start.
- R6: The four unused bits are sent as 1, with `tx_oe` = 1.
- R7: After bit 28 the line is released (`tx_oe` = 0, `tx_bit` = 1) until the next frame start.
- R8: While `pd_n` is 0, `tx_oe` is 0 and `tx_bit` is 1 in the same cycle, and frame syncs are ignored. A frame cut off by `pd_n` does not resume when `pd_n` returns high.
- R9: Changes on the data inputs after the frame start do not alter the frame being sent.
- R10: A sync held high for several cycles starts exactly one frame. A new sync rising edge in the middle of a frame abandons that frame and starts a new one at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; the line changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_n | input | 1 | Global power-down, active low |
| fsync | input | 1 | Transmit frame sync; its rising edge starts a frame |
| pcm_a | input | 8 | Channel A compressed sample (sign in MSB) |
| pcm_b | input | 8 | Channel B compressed sample |
| lat_a | input | 3 | Channel A latched control outputs to echo |
| lat_b | input | 3 | Channel B latched control outputs to echo |
| pwr_a | input | 1 | Channel A power bit (1 = operating) |
| pwr_b | input | 1 | Channel B power bit (1 = operating) |
| tx_bit | output | 1 | Line level as seen with the pull-up (1 when released) |
| tx_oe | output | 1 | 1 while the block drives the serial line |

## Verification
The assertions assume that `fsync` and all data inputs change only between rising clock edges. They also assume that `rst_n` is released while `fsync` is low, so the first sync the block sees is a true rising edge. The bench drives every input on the falling clock edge and keeps `fsync` low through reset. It spaces syncs at least 29 cycles apart, except where R10 deliberately restarts a frame mid-way. Power-down is applied only between driven edges, so the same-cycle release seen at the ports follows from `pd_n` alone.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
    // Level the line takes when the driver lets go (pull-up)
    localparam logic LINE_RELEASED = 1'b1;
    // Fill value used for idle samples and unused slots
    localparam logic FILL_BIT = 1'b1;
endpackage

// File: rtl/ptx_chan_slot.sv
module ptx_chan_slot #(
    parameter int PCM_W = 8,
    parameter int LAT_W = 3,
    localparam int SLOT_W = PCM_W + 1 + LAT_W
) (
    input  logic [PCM_W-1:0]  pcm,
    input  logic [LAT_W-1:0]  lat,
    input  logic              pwr,
    output logic [SLOT_W-1:0] slot
);
    import ptx_pkg::*;

    logic [PCM_W-1:0] sample;

    always_comb begin
        // A powered-down channel sends the idle code
        sample = pwr ? pcm : {PCM_W{FILL_BIT}};
        slot   = {sample, pwr, lat};
    end
endmodule

// File: rtl/ptx_frame_pack.sv
module ptx_frame_pack #(
    parameter int PCM_W = 8,
    parameter int LAT_W = 3,
    parameter int GAP_W = 4,
    localparam int SLOT_W  = PCM_W + 1 + LAT_W,
    localparam int FRAME_W = 2 * SLOT_W + GAP_W
) (
    input  logic [PCM_W-1:0]   pcm_a,
    input  logic [PCM_W-1:0]   pcm_b,
    input  logic [LAT_W-1:0]   lat_a,
    input  logic [LAT_W-1:0]   lat_b,
    input  logic               pwr_a,
    input  logic               pwr_b,
    output logic [FRAME_W-1:0] frame
);
    import ptx_pkg::*;

    logic [1:0][PCM_W-1:0]  pcm_v;
    logic [1:0][LAT_W-1:0]  lat_v;
    logic [1:0]             pwr_v;
    logic [1:0][SLOT_W-1:0] slot_v;

    assign pcm_v = {pcm_b, pcm_a};
    assign lat_v = {lat_b, lat_a};
    assign pwr_v = {pwr_b, pwr_a};

    for (genvar ch = 0; ch < 2; ch++) begin : g_slot
        ptx_chan_slot #(.PCM_W(PCM_W), .LAT_W(LAT_W)) u_slot (
            .pcm  (pcm_v[ch]),
            .lat  (lat_v[ch]),
            .pwr  (pwr_v[ch]),
            .slot (slot_v[ch])
        );
    end

    // Channel A leads, the unused gap follows its echo bits
    assign frame = {slot_v[0], {GAP_W{FILL_BIT}}, slot_v[1]};
endmodule

// File: rtl/ptx_sync_detect.sv
module ptx_sync_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic fsync,
    output logic start
);
    logic fs_d, fs_q;

    always_comb begin
        fs_d  = fsync;
        start = fsync & ~fs_q & pd_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= 1'b0;
        else        fs_q <= fs_d;
    end
endmodule

// File: rtl/ptx_serializer.sv
module ptx_serializer #(
    parameter int FRAME_W = 28,
    localparam int CNT_W = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               busy,
    output logic               line
);
    import ptx_pkg::*;

    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   left;
        logic [FRAME_W-1:0] shadow;
        logic               line;
    } ser_state_t;

    localparam ser_state_t IDLE_STATE = '{
        busy:   1'b0,
        left:   '0,
        shadow: {FRAME_W{FILL_BIT}},
        line:   LINE_RELEASED
    };

    ser_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pd_n) begin
            st_d = IDLE_STATE;
        end else if (start) begin
            st_d.busy   = 1'b1;
            st_d.line   = frame[FRAME_W-1];
            st_d.shadow = {frame[FRAME_W-2:0], FILL_BIT};
            st_d.left   = CNT_W'(FRAME_W - 1);
        end else if (st_q.busy) begin
            if (st_q.left == '0) begin
                st_d.busy = 1'b0;
                st_d.line = LINE_RELEASED;
            end else begin
                st_d.line   = st_q.shadow[FRAME_W-1];
                st_d.shadow = {st_q.shadow[FRAME_W-2:0], FILL_BIT};
                st_d.left   = st_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IDLE_STATE;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign line = st_q.line;
endmodule

// File: rtl/pcm_tx_echo.sv
module pcm_tx_echo #(
    parameter int PCM_W = 8,
    parameter int LAT_W = 3,
    parameter int GAP_W = 4,
    localparam int FRAME_W = 2 * (PCM_W + 1 + LAT_W) + GAP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             fsync,
    input  logic [PCM_W-1:0] pcm_a,
    input  logic [PCM_W-1:0] pcm_b,
    input  logic [LAT_W-1:0] lat_a,
    input  logic [LAT_W-1:0] lat_b,
    input  logic             pwr_a,
    input  logic             pwr_b,
    output logic             tx_bit,
    output logic             tx_oe
);
    import ptx_pkg::*;

    logic               start;
    logic [FRAME_W-1:0] frame;
    logic               busy;
    logic               line;

    ptx_sync_detect u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pd_n  (pd_n),
        .fsync (fsync),
        .start (start)
    );

    ptx_frame_pack #(.PCM_W(PCM_W), .LAT_W(LAT_W), .GAP_W(GAP_W)) u_pack (
        .pcm_a (pcm_a),
        .pcm_b (pcm_b),
        .lat_a (lat_a),
        .lat_b (lat_b),
        .pwr_a (pwr_a),
        .pwr_b (pwr_b),
        .frame (frame)
    );

    ptx_serializer #(.FRAME_W(FRAME_W)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .pd_n  (pd_n),
        .start (start),
        .frame (frame),
        .busy  (busy),
        .line  (line)
    );

    // Power-down releases the open-drain line in the same cycle
    assign tx_oe  = busy & pd_n;
    assign tx_bit = tx_oe ? line : LINE_RELEASED;
endmodule

// File: rtl/ptx_checker.sv
module ptx_checker #(
    parameter int FRAME_W = 28
) (
    input logic clk,
    input logic rst_n,
    input logic pd_n,
    input logic fsync,
    input logic pwr_a,
    input logic tx_bit,
    input logic tx_oe
);
    logic       fs_prev;
    logic [7:0] run;
    logic       seen_start;

    assign seen_start = fsync & ~fs_prev & pd_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_prev <= 1'b0;
            run     <= '0;
        end else begin
            fs_prev <= fsync;
            if (seen_start)            run <= 8'd1;
            else if (tx_oe && run != 8'hFF) run <= run + 8'd1;
            else if (!tx_oe)           run <= '0;
        end
    end

    // R8: power-down releases the line
    p_release_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |-> (!tx_oe && tx_bit));

    // R7: a released line reads high
    p_released_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> tx_bit);

    // R2: a sync rising edge puts the first bit on the line
    p_start_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_start |=> (!pd_n || tx_oe));

    // R4: idle channel A leads with a one
    p_idle_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_start && !pwr_a) |=> (!pd_n || (tx_oe && tx_bit)));

    // R7: the line is never held past one frame length
    p_frame_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oe |-> (run <= 8'(FRAME_W)));
endmodule

bind pcm_tx_echo ptx_checker #(.FRAME_W(FRAME_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pd_n   (pd_n),
    .fsync  (fsync),
    .pwr_a  (pwr_a),
    .tx_bit (tx_bit),
    .tx_oe  (tx_oe)
);

// File: tb/pcm_tx_echo_tb.sv
module pcm_tx_echo_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_n = 1'b1;
    logic       fsync = 1'b0;
    logic [7:0] pcm_a = '0, pcm_b = '0;
    logic [2:0] lat_a = '0, lat_b = '0;
    logic       pwr_a = 1'b1, pwr_b = 1'b1;
    logic       tx_bit, tx_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    pcm_tx_echo u_dut (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .fsync(fsync),
        .pcm_a(pcm_a), .pcm_b(pcm_b), .lat_a(lat_a), .lat_b(lat_b),
        .pwr_a(pwr_a), .pwr_b(pwr_b), .tx_bit(tx_bit), .tx_oe(tx_oe)
    );

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {oe,bit} actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected bit n (1-based) from the R3 layout
    function automatic logic exp_bit(input int n, input logic [7:0] a, input logic [7:0] b,
                                     input logic [2:0] la, input logic [2:0] lb,
                                     input logic pa, input logic pb);
        logic [7:0] sa, sb;
        sa = pa ? a : 8'hFF;
        sb = pb ? b : 8'hFF;
        if (n <= 8)  return sa[8-n];
        if (n == 9)  return pa;
        if (n <= 12) return la[12-n];
        if (n <= 16) return 1'b1;
        if (n <= 24) return sb[24-n];
        if (n == 25) return pb;
        return lb[28-n];
    endfunction

    function automatic string bit_tag(input int n, input logic pa, input logic pb);
        if (n == 1 && pa) return "R2";
        if ((n <= 8 && !pa) || (n >= 17 && n <= 24 && !pb)) return "R4";
        if ((n >= 9 && n <= 12) || n >= 25) return "R5";
        if (n >= 13 && n <= 16) return "R6";
        return "R3";
    endfunction

    // Driver: start a frame, push expected line states for `keep` bits
    task automatic launch(input logic [7:0] a, input logic [7:0] b,
                          input logic [2:0] la, input logic [2:0] lb,
                          input logic pa, input logic pb,
                          input int keep, input int width, input bit scramble,
                          input string extra);
        @(negedge clk);
        pcm_a = a; pcm_b = b; lat_a = la; lat_b = lb; pwr_a = pa; pwr_b = pb;
        fsync = 1'b1;
        for (int n = 1; n <= keep; n++) begin
            exp_q.push_back({1'b1, exp_bit(n, a, b, la, lb, pa, pb)});
            tag_q.push_back({bit_tag(n, pa, pb), extra});
        end
        if (keep == 28) begin
            for (int r = 0; r < 3; r++) begin
                exp_q.push_back(2'b01);
                tag_q.push_back({"R7", extra});
            end
        end
        for (int w = 1; w <= keep + 4; w++) begin
            if (w == keep && keep < 28) break;
            @(negedge clk);
            if (w >= width) fsync = 1'b0;
            if (scramble) begin
                pcm_a = ~pcm_a; pcm_b = pcm_b + 8'd37;
                lat_a = ~lat_a; lat_b = lat_b + 3'd3;
                pwr_a = ~pwr_a; pwr_b = ~pwr_b;
            end
        end
        fsync = 1'b0;
    endtask

    // Monitor: pop and compare one item per clock, away from the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {tx_oe, tx_bit}, e);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {tx_oe, tx_bit}, 2'b01);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", {tx_oe, tx_bit}, 2'b01);

        // R3 full-scale samples, both channels on
        launch(8'h80, 8'h00, 3'b101, 3'b010, 1'b1, 1'b1, 28, 1, 1'b0, "");
        // R4 channel A powered down
        launch(8'h35, 8'hC6, 3'b011, 3'b110, 1'b0, 1'b1, 28, 1, 1'b0, "");
        // R4 channel B powered down
        launch(8'h5A, 8'h21, 3'b100, 3'b001, 1'b1, 1'b0, 28, 1, 1'b0, "");
        // R4 both powered down
        launch(8'h12, 8'h34, 3'b111, 3'b000, 1'b0, 1'b0, 28, 1, 1'b0, "");
        // R3 plus and minus zero codes
        launch(8'hFF, 8'h7F, 3'b000, 3'b111, 1'b1, 1'b1, 28, 1, 1'b0, "");
        // R9 inputs change every cycle after the start
        launch(8'h6B, 8'h94, 3'b010, 3'b101, 1'b1, 1'b1, 28, 1, 1'b1, " R9");
        // R10 wide sync starts one frame only
        launch(8'hA5, 8'h3C, 3'b110, 3'b011, 1'b1, 1'b1, 28, 4, 1'b0, " R10");
        // R10 restart in mid-frame
        launch(8'h0F, 8'hF0, 3'b001, 3'b100, 1'b1, 1'b1, 10, 1, 1'b0, " R10");
        launch(8'hC3, 8'h18, 3'b101, 3'b110, 1'b1, 1'b1, 28, 1, 1'b0, " R10");
        wait (exp_q.size() == 0);

        // R8 power-down in mid-frame
        @(negedge clk);
        pcm_a = 8'h00; pcm_b = 8'h00; pwr_a = 1'b1; pwr_b = 1'b1;
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 frame running before power-down", {tx_oe, tx_bit}, 2'b10);
        pd_n = 1'b0;
        #1;
        check("R8 same-cycle release", {tx_oe, tx_bit}, 2'b01);
        @(negedge clk);
        fsync = 1'b1;
        @(negedge clk);
        check("R8 sync ignored while down", {tx_oe, tx_bit}, 2'b01);
        fsync = 1'b0;
        @(negedge clk);
        pd_n = 1'b1;
        #1;
        check("R8 no resume on wake", {tx_oe, tx_bit}, 2'b01);
        repeat (3) @(negedge clk);
        check("R8 still released after wake", {tx_oe, tx_bit}, 2'b01);

        // R7 after a frame, line stays released until the next sync
        launch(8'h00, 8'h00, 3'b000, 3'b000, 1'b1, 1'b1, 28, 1, 1'b0, "");
        wait (exp_q.size() == 0);
        repeat (5) @(negedge clk);
        check("R7 released between frames", {tx_oe, tx_bit}, 2'b01);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule